// File: doc/BRIEF.md
# Four-Channel Shared-Counter Pulse-Width Generator

This block drives four pulse-width outputs from a single period counter. The counter advances once every 2^prescale clock cycles and either wraps after reaching a programmable top value (edge-aligned mode) or climbs to the top and descends back to zero (center-aligned mode). Every channel compares the counter against its own 16-bit control word. That word holds a 15-bit threshold in bits [14:0] and a polarity flag in bit 15.

Software programs the block through a simple write port that reaches a small register bank. The bank holds the top value, the prescale exponent, the count mode, the idle levels and the four control words. A start strobe copies the banked settings into the live counter and channels. A stop strobe lets the running period finish before the outputs go back to their idle levels. While the block is stopped, a status output is high. Changes to the control words reach the outputs only after a start strobe, and they take effect on a period boundary, so a waveform is never cut partway through.

Top module: `quad_pwm`

## Requirements
- R1: During and after reset, `stopped` is 1 and every output is 0. The idle levels, top, prescale, mode and control words all reset to 0.
- R2: While running, a channel whose control word has bit 15 = 1 is high while the counter is below bits [14:0] and low otherwise. With bit 15 = 0 the output is the inverse.
- R3: A threshold of 0 keeps the channel inactive for the whole period: low when bit 15 = 1, high when bit 15 = 0.
- R4: A threshold equal to or above the live top value keeps the channel active for the whole period.
- R5: Edge-aligned mode (write address 2, bit 0 = 0) counts 0,1,...,top and then wraps, giving a period of top+1 counter steps. A top value of 0 acts as 1.
- R6: Center-aligned mode (write address 2, bit 0 = 1) counts 0 up to top and back down through 1, giving a period of 2*top steps. The channel comparison applies on both slopes.
- R7: Each counter step lasts 2^p clock cycles, where p is bits [2:0] of write address 1. The first step begins in the cycle after the start strobe is taken.
- R8: A stop strobe taken while running lets the current period complete. In the cycle after the last step of that period, `stopped` is 1 and every output shows its idle level.
- R9: A start strobe that arrives after a stop strobe but before the final period ends has no effect. The block still stops at that period's end and stays stopped.
- R10: Writes to the control words (addresses 4 to 7 for channels 0 to 3) do not change the outputs by themselves. A start strobe taken while running loads them at the next period boundary.
- R11: While stopped, output k equals bit k of the idle-level register (address 3), and a write to that register shows at the outputs in the next cycle.
- R12: Top, prescale and mode are captured only by a start strobe taken while stopped. Writing them while running leaves the running waveform unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| start | input | 1 | Start or reload strobe |
| stop | input | 1 | Stop strobe, honoured at period end |
| stopped | output | 1 | High while no waveform is generated |
| pwm_out | output | 4 | Channel outputs |

## Verification
The bench aims at the threshold edges: a threshold of zero, a threshold exactly equal to top, and inverted polarity. A design with an off-by-one compare would let a pulse slip through at zero or produce a one-step gap at the top. It times stop requests in the middle of a period and adds a start strobe during the drain. A design that cut the waveform early, stopped one period late, or restarted on the ignored strobe would mismatch on a specific cycle. It also rewrites the control words and the top value during a run, which catches designs that apply new words straight away, at the wrong boundary, or that let a new top leak into the running period. Center-aligned runs with a non-zero prescaler check where the counter turns around and how long each step is held.

// File: rtl/pwm_pkg.sv
`timescale 1ns/1ps
// pwm_pkg: shared state encoding and register addresses for quad_pwm.
// Assumes the channel words sit at consecutive addresses from CH_BASE.
package pwm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } run_state_t;

    localparam int unsigned ADR_TOP  = 0;
    localparam int unsigned ADR_PRE  = 1;
    localparam int unsigned ADR_MODE = 2;
    localparam int unsigned ADR_IDLE = 3;
    localparam int unsigned CH_BASE  = 4;
    localparam int unsigned WORD_W   = 16;
    localparam int unsigned THR_W    = 15;
endpackage

// File: rtl/pwm_regs.sv
`timescale 1ns/1ps
// pwm_regs: register bank written through a single-cycle write port.
// Holds banked settings only; nothing here affects the live waveform
// until the timebase issues a capture. Assumes TOP_W <= 15.
module pwm_regs
    import pwm_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int TOP_W  = 15,
    parameter int PRE_W  = 3,
    parameter int ADDR_W = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [WORD_W-1:0]              wr_data,
    output logic [TOP_W-1:0]               top_cfg,
    output logic [PRE_W-1:0]               pre_cfg,
    output logic                           mode_cfg,
    output logic [NUM_CH-1:0]              idle_cfg,
    output logic [NUM_CH-1:0][WORD_W-1:0]  word_cfg
);
    // Decode writes into the banked settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_cfg  <= '0;
            pre_cfg  <= '0;
            mode_cfg <= 1'b0;
            idle_cfg <= '0;
            word_cfg <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_W'(ADR_TOP))  top_cfg  <= wr_data[TOP_W-1:0];
            if (wr_addr == ADDR_W'(ADR_PRE))  pre_cfg  <= wr_data[PRE_W-1:0];
            if (wr_addr == ADDR_W'(ADR_MODE)) mode_cfg <= wr_data[0];
            if (wr_addr == ADDR_W'(ADR_IDLE)) idle_cfg <= wr_data[NUM_CH-1:0];
            for (int ch = 0; ch < NUM_CH; ch++) begin
                if (wr_addr == ADDR_W'(CH_BASE + ch)) word_cfg[ch] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/pwm_timebase.sv
`timescale 1ns/1ps
// pwm_timebase: prescaler, shared period counter and run/drain/idle control.
// Captures top, prescale and mode on a start from idle. A stop is
// honoured at the end of the period in progress; a start during the
// drain is discarded. Emits a one-cycle load pulse for channel words.
module pwm_timebase
    import pwm_pkg::*;
#(
    parameter int TOP_W = 15,
    parameter int PRE_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             stop,
    input  logic [TOP_W-1:0] top_cfg,
    input  logic [PRE_W-1:0] pre_cfg,
    input  logic             mode_cfg,
    output logic [TOP_W-1:0] cnt,
    output logic [TOP_W-1:0] top_act,
    output logic             running,
    output logic             stopped,
    output logic             load_words
);
    localparam int DIV_W = (1 << PRE_W) - 1;

    run_state_t       state;
    logic [PRE_W-1:0] pre_act;
    logic             mode_act;
    logic             dir_dn;
    logic             reload_pend;
    logic [DIV_W-1:0] prediv;
    logic [DIV_W-1:0] div_mask;
    logic             tick;
    logic             descending;
    logic             at_end;
    logic             period_end;
    logic [TOP_W-1:0] cnt_nxt;
    logic             dir_nxt;

    // Step strobe: the divider wraps after 2^pre_act cycles.
    always_comb begin
        div_mask = (DIV_W'(1) << pre_act) - DIV_W'(1);
        tick     = (prediv == div_mask);
    end

    // Period position decode and next counter value.
    always_comb begin
        descending = mode_act && (dir_dn || (cnt == top_act));
        at_end     = mode_act ? (descending && (cnt == TOP_W'(1)))
                              : (cnt == top_act);
        period_end = running && tick && at_end;
        if (at_end) begin
            cnt_nxt = '0;
            dir_nxt = 1'b0;
        end else if (descending) begin
            cnt_nxt = cnt - TOP_W'(1);
            dir_nxt = 1'b1;
        end else begin
            cnt_nxt = cnt + TOP_W'(1);
            dir_nxt = 1'b0;
        end
    end

    assign running = (state != ST_IDLE);
    assign stopped = (state == ST_IDLE);

    // Channel words load on a start from idle, or at a boundary after a live start.
    assign load_words = ((state == ST_IDLE) && start) ||
                        ((state == ST_RUN) && period_end &&
                         (reload_pend || (start && !stop)));

    // Run control, settings capture and counter stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            cnt         <= '0;
            dir_dn      <= 1'b0;
            prediv      <= '0;
            top_act     <= TOP_W'(1);
            pre_act     <= '0;
            mode_act    <= 1'b0;
            reload_pend <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state       <= ST_RUN;
                        top_act     <= (top_cfg == '0) ? TOP_W'(1) : top_cfg;
                        pre_act     <= pre_cfg;
                        mode_act    <= mode_cfg;
                        cnt         <= '0;
                        dir_dn      <= 1'b0;
                        prediv      <= '0;
                        reload_pend <= 1'b0;
                    end
                end
                ST_RUN, ST_DRAIN: begin
                    prediv <= tick ? '0 : prediv + DIV_W'(1);
                    if (tick) begin
                        cnt    <= cnt_nxt;
                        dir_dn <= dir_nxt;
                    end
                    if (state == ST_RUN) begin
                        if (stop) state <= ST_DRAIN;
                        reload_pend <= !period_end && (reload_pend || (start && !stop));
                    end else if (period_end) begin
                        state       <= ST_IDLE;
                        cnt         <= '0;
                        dir_dn      <= 1'b0;
                        prediv      <= '0;
                        reload_pend <= 1'b0;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R5: the live counter never passes the captured top
    p_cnt_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (cnt <= top_act));

    // R7: between step strobes the counter holds its value
    p_step_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !tick) |=> $stable(cnt));

    // R9: once draining, the block never returns to the run state directly
    p_drain_no_resume_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN) |=> (state != ST_RUN));

    // R8: the stopped flag only rises right after a completed period
    p_stop_at_boundary_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stopped) |-> $past(period_end));

    // R1: an idle timebase keeps its counter parked at zero
    p_idle_parked_r1: assert property (@(posedge clk) disable iff (!rst_n)
        stopped |-> (cnt == '0));
endmodule

// File: rtl/pwm_channel.sv
`timescale 1ns/1ps
// pwm_channel: one output. Keeps a live copy of its control word that
// changes only on the load pulse, compares the shared counter with the
// threshold and applies polarity; shows the idle level when not running.
module pwm_channel
    import pwm_pkg::*;
#(
    parameter int TOP_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word_cfg,
    input  logic [TOP_W-1:0]  cnt,
    input  logic [TOP_W-1:0]  top_act,
    input  logic              running,
    input  logic              idle_lvl,
    output logic              pwm_o
);
    logic [WORD_W-1:0] word_act;
    logic [THR_W-1:0]  thr;
    logic              pol;
    logic              active;

    // Live control word, replaced only on a load pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) word_act <= '0;
        else if (load) word_act <= word_cfg;
    end

    // Threshold compare with saturation at the top value.
    always_comb begin
        thr    = word_act[THR_W-1:0];
        pol    = word_act[WORD_W-1];
        active = (thr != '0) &&
                 ((thr >= THR_W'(top_act)) || (THR_W'(cnt) < thr));
        pwm_o  = running ? (pol ? active : !active) : idle_lvl;
    end

    // R10: the live word is untouched without a load pulse
    p_word_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(word_act));

    // R3: a zero threshold never produces the active level
    p_zero_inactive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (running && (word_act[THR_W-1:0] == '0)) |-> (pwm_o == !word_act[WORD_W-1]));

    // R4: a threshold at or above top always produces the active level
    p_full_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (running && (word_act[THR_W-1:0] != '0) &&
         (word_act[THR_W-1:0] >= THR_W'(top_act))) |-> (pwm_o == word_act[WORD_W-1]));
endmodule

// File: rtl/quad_pwm.sv
`timescale 1ns/1ps
// quad_pwm: top level. Register bank, shared timebase and one channel
// slice per output. Assumes NUM_CH <= 16 and TOP_W <= 15.
module quad_pwm
    import pwm_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int TOP_W  = 15,
    parameter int PRE_W  = 3,
    localparam int ADDR_W = $clog2(CH_BASE + NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              start,
    input  logic              stop,
    output logic              stopped,
    output logic [NUM_CH-1:0] pwm_out
);
    logic [TOP_W-1:0]              top_cfg;
    logic [PRE_W-1:0]              pre_cfg;
    logic                          mode_cfg;
    logic [NUM_CH-1:0]             idle_cfg;
    logic [NUM_CH-1:0][WORD_W-1:0] word_cfg;
    logic [TOP_W-1:0]              cnt;
    logic [TOP_W-1:0]              top_act;
    logic                          running;
    logic                          load_words;

    pwm_regs #(
        .NUM_CH (NUM_CH),
        .TOP_W  (TOP_W),
        .PRE_W  (PRE_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .top_cfg  (top_cfg),
        .pre_cfg  (pre_cfg),
        .mode_cfg (mode_cfg),
        .idle_cfg (idle_cfg),
        .word_cfg (word_cfg)
    );

    pwm_timebase #(
        .TOP_W (TOP_W),
        .PRE_W (PRE_W)
    ) u_timebase (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .stop       (stop),
        .top_cfg    (top_cfg),
        .pre_cfg    (pre_cfg),
        .mode_cfg   (mode_cfg),
        .cnt        (cnt),
        .top_act    (top_act),
        .running    (running),
        .stopped    (stopped),
        .load_words (load_words)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        pwm_channel #(
            .TOP_W (TOP_W)
        ) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (load_words),
            .word_cfg (word_cfg[ch]),
            .cnt      (cnt),
            .top_act  (top_act),
            .running  (running),
            .idle_lvl (idle_cfg[ch]),
            .pwm_o    (pwm_out[ch])
        );
    end

    // R11: while stopped, outputs follow the idle register
    p_idle_outputs_r11: assert property (@(posedge clk) disable iff (!rst_n)
        stopped |-> (pwm_out == idle_cfg));
endmodule

// File: tb/quad_pwm_tb.sv
`timescale 1ns/1ps
module quad_pwm_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        start = 1'b0;
    logic        stop = 1'b0;
    logic        stopped;
    logic [3:0]  pwm_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // banked (written) and live (model) settings
    logic [15:0] cfg_w [4];
    int          cfg_top = 0, cfg_pre = 0, cfg_mode = 0;
    logic [3:0]  cfg_idle = '0;
    logic [15:0] live_w [4];
    logic [15:0] next_w [4];
    int          m_top = 1, m_pre = 0, m_mode = 0;
    int          n = 0;
    int          sw_idx = -1;

    always #4 clk = ~clk;

    quad_pwm u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .start(start), .stop(stop),
        .stopped(stopped), .pwm_out(pwm_out)
    );

    function automatic int per_len();
        return (m_mode != 0 ? 2 * m_top : m_top + 1) * (1 << m_pre);
    endfunction

    function automatic logic [3:0] model(int idx);
        logic [3:0] r;
        int steps = m_mode != 0 ? 2 * m_top : m_top + 1;
        int pos = (idx >> m_pre) % steps;
        int c = (m_mode == 0 || pos <= m_top) ? pos : 2 * m_top - pos;
        for (int ch = 0; ch < 4; ch++) begin
            int thr = int'(live_w[ch][14:0]);
            logic on = (thr != 0) && (thr >= m_top || c < thr);
            r[ch] = live_w[ch][15] ? on : !on;
        end
        return r;
    endfunction

    task automatic chk(string tag, logic [3:0] exp_o, logic exp_s);
        n_chk++;
        if (pwm_out !== exp_o || stopped !== exp_s) begin
            n_fail++;
            $display("FAIL %s: sample %0d out=%b stopped=%b, expected out=%b stopped=%b",
                     tag, n, pwm_out, stopped, exp_o, exp_s);
        end
    endtask

    task automatic live_step(string tag);
        if (n == sw_idx) live_w = next_w;
        chk(tag, model(n), 1'b0);
        n++;
        @(negedge clk);
    endtask

    task automatic run_win(int len, string tag);
        for (int i = 0; i < len; i++) live_step(tag);
    endtask

    task automatic wr(int a, logic [15:0] d, bit live, string tag);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
        if (a >= 4) cfg_w[a-4] = d;
        if (a == 0) cfg_top = int'(d[14:0]);
        if (a == 1) cfg_pre = int'(d[2:0]);
        if (a == 2) cfg_mode = int'(d[0]);
        if (a == 3) cfg_idle = d[3:0];
        if (live) begin
            if (n == sw_idx) live_w = next_w;
            chk(tag, model(n), 1'b0);
            n++;
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic start_from_idle();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        m_top = cfg_top == 0 ? 1 : cfg_top;
        m_pre = cfg_pre; m_mode = cfg_mode;
        live_w = cfg_w;
        n = 0; sw_idx = -1;
    endtask

    task automatic stop_drain(bit inject, string tag);
        int n_s, e;
        stop = 1'b1;
        if (n == sw_idx) live_w = next_w;
        chk(tag, model(n), 1'b0);
        n_s = n; n++;
        @(negedge clk);
        stop = 1'b0;
        e = ((n_s + 1) / per_len() + 1) * per_len() - 1;
        if (inject && e > n) begin
            start = 1'b1;
            live_step(tag);
            start = 1'b0;
        end
        run_win(e - n + 1, tag);
        chk(tag, cfg_idle, 1'b1);
    endtask

    // R1: reset state
    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 reset", 4'b0000, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", 4'b0000, 1'b1);
    endtask

    // R11, R10: idle levels and word writes while stopped
    task automatic t_idle();
        wr(3, 16'h000A, 0, "R11");
        chk("R11 idle level", 4'b1010, 1'b1);
        wr(4, 16'h8003, 0, "R10");
        repeat (3) begin chk("R10 word write while idle", 4'b1010, 1'b1); @(negedge clk); end
        wr(3, 16'h0005, 0, "R11");
        chk("R11 idle level change", 4'b0101, 1'b1);
    endtask

    // R2 R3 R4 R5 R8: edge-aligned run and stop
    task automatic t_edge();
        wr(0, 16'd9, 0, "R5"); wr(1, 16'd0, 0, "R7"); wr(2, 16'd0, 0, "R5");
        wr(4, 16'h8003, 0, "R2"); wr(5, 16'h0003, 0, "R2");
        wr(6, 16'h8000, 0, "R3"); wr(7, 16'h8009, 0, "R4");
        start_from_idle();
        run_win(34, "R2 R3 R4 R5 edge-aligned");
        stop_drain(0, "R8 stop at period end");
        repeat (5) begin @(negedge clk); chk("R8 stays idle", cfg_idle, 1'b1); end
        @(negedge clk);
    endtask

    // R6 R7: center-aligned with prescale
    task automatic t_center();
        wr(0, 16'd6, 0, "R6"); wr(1, 16'd1, 0, "R7"); wr(2, 16'd1, 0, "R6");
        wr(4, 16'h8002, 0, "R6"); wr(5, 16'h0004, 0, "R6");
        wr(6, 16'h8006, 0, "R4"); wr(7, 16'h8001, 0, "R6");
        start_from_idle();
        run_win(3 * per_len() + 5, "R6 R7 center-aligned");
        stop_drain(0, "R8 center stop");
        @(negedge clk);
    endtask

    // R9: start during drain is ignored
    task automatic t_ignored_start();
        wr(0, 16'd7, 0, "R9"); wr(1, 16'd0, 0, "R9"); wr(2, 16'd0, 0, "R9");
        wr(4, 16'h8004, 0, "R9");
        start_from_idle();
        run_win(3, "R9 run");
        stop_drain(1, "R9 start during drain");
        repeat (12) begin @(negedge clk); chk("R9 remains stopped", cfg_idle, 1'b1); end
        @(negedge clk);
    endtask

    // R5: top of zero behaves as one
    task automatic t_top_zero();
        wr(0, 16'd0, 0, "R5"); wr(1, 16'd2, 0, "R5"); wr(2, 16'd0, 0, "R5");
        wr(4, 16'h8001, 0, "R5"); wr(5, 16'h0000, 0, "R5");
        start_from_idle();
        run_win(5, "R5 top zero");
        stop_drain(0, "R5 top zero period length");
        @(negedge clk);
    endtask

    // R10 R12: live rewrites, reload at boundary, top held
    task automatic t_reload();
        wr(0, 16'd7, 0, "R12"); wr(1, 16'd2, 0, "R12"); wr(2, 16'd0, 0, "R12");
        wr(4, 16'h8002, 0, "R10"); wr(5, 16'h8005, 0, "R10");
        wr(6, 16'h0000, 0, "R10"); wr(7, 16'h8000, 0, "R10");
        start_from_idle();
        run_win(10, "R10 run");
        wr(4, 16'h8006, 1, "R10"); wr(7, 16'h0003, 1, "R10");
        wr(0, 16'd3, 1, "R12"); wr(2, 16'd1, 1, "R12");
        run_win(per_len(), "R10 R12 no effect before start");
        start = 1'b1;
        next_w = cfg_w;
        sw_idx = (n / per_len() + 1) * per_len();
        live_step("R10 live start");
        start = 1'b0;
        run_win(2 * per_len(), "R10 reload at boundary, R12 top held");
        stop_drain(0, "R8 stop after reload");
        @(negedge clk);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin cfg_w[i] = '0; live_w[i] = '0; next_w[i] = '0; end
        @(negedge clk);
        t_reset();
        t_idle();
        t_edge();
        t_center();
        t_ignored_start();
        t_top_zero();
        t_reload();
        finish_up();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_up();
    end
endmodule